// File: doc/BRIEF.md
# Interleaved CPU/DMA Memory Slot Arbiter

This block lets a CPU with no control over bus timing and a DMA engine share one memory port. Time is divided into fixed slots of `SLOT_CYCLES` clock cycles. A free-running slot timer marks the last cycle of every slot with `slot_strobe`, and all ownership decisions are taken on that cycle for the slot that follows.

A CPU access is always split across two or more slots. In the first slot the arbiter only captures the CPU's address, write flag and write data into its own registers. The memory port stays free in that slot, so a DMA transfer can use it. The CPU data transfer takes a later slot. If DMA asks for that slot, DMA wins. The CPU is then held with a wait indication and retries at each following slot boundary until it finds one with no DMA demand. The data the CPU reads is kept in a separate register that only a completing CPU read can update, so DMA traffic never changes what the CPU sees. A DMA request is also latched at its slot boundary. The DMA engine can therefore change its inputs for the next decision while its granted slot is still running.

Top module: `slot_arbiter`

## Requirements
- R1: `slot_strobe` is high for exactly one cycle in every `SLOT_CYCLES` cycles. Its first pulse comes `SLOT_CYCLES-1` cycles after reset is released.
- R2: With no DMA demand, a CPU access takes exactly two slots. `cpu_ready` is seen `2*SLOT_CYCLES+1` cycles after the strobe cycle in which `cpu_req` was accepted.
- R3: The slot after a CPU acceptance is the address slot. The CPU does not drive memory in it. If `dma_req` was high at the accepting strobe, that DMA transfer owns the memory port during the address slot.
- R4: `dma_req` sampled high on a strobe cycle grants DMA the whole next slot. During that slot `dma_gnt`=1, and `mem_en`=1 with the address, write flag and data latched from the DMA inputs. DMA and the CPU data transfer never own the same slot.
- R5: While DMA claims the CPU's pending data slot, `cpu_wait`=1 and the transfer moves back one slot at a time. With DMA demand on every slot, the CPU waits indefinitely and no `cpu_ready` appears.
- R6: `cpu_ready` is a one-cycle pulse on the first cycle of the slot after the CPU data slot. For a read, `cpu_rdata` holds the memory word on that cycle.
- R7: The CPU address, write flag and write data are captured at acceptance and held until ready. Changes on the CPU inputs during an access have no effect. A new request is accepted only at a strobe after ready.
- R8: `cpu_rdata` changes only on a `cpu_ready` cycle that ends a read. DMA reads and writes leave it unchanged.
- R9: A CPU access can start at any slot boundary, whether odd or even.
- R10: A CPU write stores `cpu_wdata` at the captured address. A CPU read returns the last value written there. `dma_rdata` carries the memory word during a DMA grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | CPU access request, held until ready |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| cpu_addr | input | AW | CPU word address |
| cpu_wdata | input | DW | CPU write data |
| cpu_rdata | output | DW | CPU read data register |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_wait | output | 1 | CPU data slot taken by DMA |
| dma_req | input | 1 | DMA request for the next slot |
| dma_we | input | 1 | DMA write (1) or read (0) |
| dma_addr | input | AW | DMA word address |
| dma_wdata | input | DW | DMA write data |
| dma_gnt | output | 1 | DMA owns the current slot |
| dma_rdata | output | DW | Memory read data for DMA |
| mem_en | output | 1 | Memory port active this slot |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| slot_strobe | output | 1 | Last cycle of a slot, decision point |

## Verification
The bench first runs CPU accesses with no DMA load. This isolates the basic two-slot timing, shows that the address slot leaves memory idle, and places starts on both slot parities through gaps of varying length. It then keeps one CPU access pending while DMA claims every slot. This separates true DMA priority from a fairness scheme, because the CPU must stay in wait for the whole period and finish only once DMA lets go. Finally, random DMA demand is mixed with random CPU reads and writes. A reference memory and a per-access count of wait slots then detect lost writes, stale read data, read-data corruption by DMA, and ready pulses that come a slot early or late.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;

  typedef enum logic [1:0] {
    CPU_IDLE = 2'd0,
    CPU_ADDR = 2'd1,
    CPU_WAIT = 2'd2,
    CPU_XFER = 2'd3
  } cpu_phase_e;

  // Phase the CPU side moves to at a slot boundary.
  function automatic cpu_phase_e phase_next(cpu_phase_e cur, logic req, logic dma_claim);
    cpu_phase_e nxt;
    case (cur)
      CPU_IDLE: nxt = req ? CPU_ADDR : CPU_IDLE;
      CPU_ADDR,
      CPU_WAIT: nxt = dma_claim ? CPU_WAIT : CPU_XFER;
      default:  nxt = CPU_IDLE;
    endcase
    return nxt;
  endfunction

  // Cycles from the accepting strobe to the ready cycle.
  function automatic int unsigned access_latency(int unsigned slot_cycles, int unsigned waits);
    return (2 + waits) * slot_cycles + 1;
  endfunction

endpackage

// File: rtl/slot_timer.sv
module slot_timer #(
  parameter int SLOT_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic slot_strobe
);
  localparam int CW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOT_CYCLES - 1);

  logic [CW-1:0] cyc_in_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cyc_in_slot <= '0;
    else if (cyc_in_slot == LAST) cyc_in_slot <= '0;
    else                         cyc_in_slot <= cyc_in_slot + 1'b1;
  end

  assign slot_strobe = (cyc_in_slot == LAST);
endmodule

// File: rtl/slot_cpu_side.sv
module slot_cpu_side
  import slot_arb_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_strobe,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          dma_req,
  input  logic [DW-1:0] mem_rdata,
  output cpu_phase_e    phase,
  output logic          cap_we,
  output logic [AW-1:0] cap_addr,
  output logic [DW-1:0] cap_wdata,
  output logic          cpu_ready,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_wait,
  output logic          cpu_xfer
);
  logic accept;
  logic finish;

  assign accept = slot_strobe && (phase == CPU_IDLE) && cpu_req;
  assign finish = slot_strobe && (phase == CPU_XFER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= CPU_IDLE;
      cap_we    <= 1'b0;
      cap_addr  <= '0;
      cap_wdata <= '0;
      cpu_ready <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      cpu_ready <= finish;
      if (slot_strobe) phase <= phase_next(phase, cpu_req, dma_req);
      if (accept) begin
        cap_we    <= cpu_we;
        cap_addr  <= cpu_addr;
        cap_wdata <= cpu_wdata;
      end
      if (finish && !cap_we) cpu_rdata <= mem_rdata;
    end
  end

  assign cpu_wait = (phase == CPU_WAIT);
  assign cpu_xfer = (phase == CPU_XFER);
endmodule

// File: rtl/slot_dma_side.sv
module slot_dma_side #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_strobe,
  input  logic          dma_req,
  input  logic          dma_we,
  input  logic [AW-1:0] dma_addr,
  input  logic [DW-1:0] dma_wdata,
  output logic          dma_gnt,
  output logic          g_we,
  output logic [AW-1:0] g_addr,
  output logic [DW-1:0] g_wdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_gnt <= 1'b0;
      g_we    <= 1'b0;
      g_addr  <= '0;
      g_wdata <= '0;
    end else if (slot_strobe) begin
      dma_gnt <= dma_req;
      if (dma_req) begin
        g_we    <= dma_we;
        g_addr  <= dma_addr;
        g_wdata <= dma_wdata;
      end
    end
  end
endmodule

// File: rtl/slot_mem_mux.sv
module slot_mem_mux #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          dma_gnt,
  input  logic          g_we,
  input  logic [AW-1:0] g_addr,
  input  logic [DW-1:0] g_wdata,
  input  logic          cpu_xfer,
  input  logic          cap_we,
  input  logic [AW-1:0] cap_addr,
  input  logic [DW-1:0] cap_wdata,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    if (dma_gnt) begin
      mem_en    = 1'b1;
      mem_we    = g_we;
      mem_addr  = g_addr;
      mem_wdata = g_wdata;
    end else if (cpu_xfer) begin
      mem_en    = 1'b1;
      mem_we    = cap_we;
      mem_addr  = cap_addr;
      mem_wdata = cap_wdata;
    end
  end
endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter
  import slot_arb_pkg::*;
#(
  parameter int SLOT_CYCLES = 2,
  parameter int AW          = 8,
  parameter int DW          = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_ready,
  output logic          cpu_wait,
  input  logic          dma_req,
  input  logic          dma_we,
  input  logic [AW-1:0] dma_addr,
  input  logic [DW-1:0] dma_wdata,
  output logic          dma_gnt,
  output logic [DW-1:0] dma_rdata,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          slot_strobe
);
  cpu_phase_e    phase;
  logic          cap_we, cpu_xfer, g_we;
  logic [AW-1:0] cap_addr, g_addr;
  logic [DW-1:0] cap_wdata, g_wdata;

  slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .slot_strobe(slot_strobe)
  );

  slot_cpu_side #(.AW(AW), .DW(DW)) u_cpu (
    .clk(clk), .rst_n(rst_n), .slot_strobe(slot_strobe),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .dma_req(dma_req), .mem_rdata(mem_rdata),
    .phase(phase), .cap_we(cap_we), .cap_addr(cap_addr), .cap_wdata(cap_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .cpu_wait(cpu_wait), .cpu_xfer(cpu_xfer)
  );

  slot_dma_side #(.AW(AW), .DW(DW)) u_dma (
    .clk(clk), .rst_n(rst_n), .slot_strobe(slot_strobe),
    .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
    .dma_gnt(dma_gnt), .g_we(g_we), .g_addr(g_addr), .g_wdata(g_wdata)
  );

  slot_mem_mux #(.AW(AW), .DW(DW)) u_mux (
    .dma_gnt(dma_gnt), .g_we(g_we), .g_addr(g_addr), .g_wdata(g_wdata),
    .cpu_xfer(cpu_xfer), .cap_we(cap_we), .cap_addr(cap_addr), .cap_wdata(cap_wdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  assign dma_rdata = mem_rdata;
endmodule

// File: rtl/slot_arbiter_chk.sv
module slot_arbiter_chk
  import slot_arb_pkg::*;
#(
  parameter int SLOT_CYCLES = 2,
  parameter int AW          = 8,
  parameter int DW          = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          slot_strobe,
  input logic          cpu_req,
  input logic          dma_req,
  input logic          dma_gnt,
  input logic          cpu_ready,
  input logic          cpu_wait,
  input logic          cpu_xfer,
  input logic [DW-1:0] cpu_rdata,
  input logic [AW-1:0] cap_addr,
  input cpu_phase_e    phase
);
  int unsigned gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           gap <= 0;
    else if (slot_strobe) gap <= 0;
    else                  gap <= gap + 1;
  end

  a_r1_strobe_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    slot_strobe |-> (gap == SLOT_CYCLES - 1));

  a_r3_addr_slot_shared: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_strobe && cpu_req && dma_req && phase == CPU_IDLE) |=> (dma_gnt && phase == CPU_ADDR));

  a_r4_dma_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_strobe && dma_req) |=> (dma_gnt && !cpu_xfer));

  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_gnt && cpu_xfer));

  a_r5_wait_means_dma: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wait |-> dma_gnt);

  a_r6_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  a_r6_ready_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> $past(cpu_xfer && slot_strobe));

  a_r7_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != CPU_IDLE) |=> $stable(cap_addr));

  a_r8_rdata_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ready |-> $stable(cpu_rdata));
endmodule

bind slot_arbiter slot_arbiter_chk #(.SLOT_CYCLES(SLOT_CYCLES), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_strobe(slot_strobe), .cpu_req(cpu_req),
  .dma_req(dma_req), .dma_gnt(dma_gnt), .cpu_ready(cpu_ready), .cpu_wait(cpu_wait),
  .cpu_xfer(cpu_xfer), .cpu_rdata(cpu_rdata), .cap_addr(cap_addr), .phase(phase)
);

// File: tb/slot_arbiter_tb.sv
module slot_arbiter_tb;
  localparam int SC    = 2;
  localparam int AW    = 8;
  localparam int DW    = 16;
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = 1 << (AW - 1);

  // bench model phases
  localparam int P_IDLE = 0, P_ADDR = 1, P_WAIT = 2, P_XFER = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 0, cpu_we = 0, dma_req = 0, dma_we = 0;
  logic [AW-1:0] cpu_addr = '0, dma_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, dma_wdata = '0;
  logic [DW-1:0] cpu_rdata, dma_rdata, mem_wdata, mem_rdata;
  logic cpu_ready, cpu_wait, dma_gnt, mem_en, mem_we, slot_strobe;
  logic [AW-1:0] mem_addr;

  always #10 clk = ~clk;

  slot_arbiter #(.SLOT_CYCLES(SC), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .cpu_wait(cpu_wait),
    .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
    .dma_gnt(dma_gnt), .dma_rdata(dma_rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .slot_strobe(slot_strobe)
  );

  // memory behind the port
  logic [DW-1:0] mem [0:DEPTH-1];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (mem_en && mem_we) begin
      mem[mem_addr] <= mem_wdata;
    end
  end
  assign mem_rdata = mem[mem_addr];

  logic [DW-1:0] ref_mem [0:DEPTH-1];

  int checks = 0, errors = 0;
  bit done = 0;
  longint cyc = 0;

  always @(negedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // bench model state
  int m = P_IDLE;
  bit cap_we_m;
  logic [AW-1:0] cap_a_m;
  logic [DW-1:0] cap_d_m;
  int waits_m = 0;
  longint acc_cyc = 0;
  logic [DW-1:0] last_rdata = '0;
  longint slot_no = 0;
  int starts_even = 0, starts_odd = 0;

  // next op
  bit nx_valid = 0, nx_we = 0;
  logic [AW-1:0] nx_a = '0;
  logic [DW-1:0] nx_d = '0;

  function automatic int model_next(int cur, bit req, bit dreq);
    if (cur == P_IDLE) return req ? P_ADDR : P_IDLE;
    if (cur == P_XFER) return P_IDLE;
    return dreq ? P_WAIT : P_XFER;
  endfunction

  function automatic longint exp_latency(int waits);
    return longint'((2 + waits) * SC + 1);
  endfunction

  // Called at the negedge of a strobe cycle; returns at the next one.
  task automatic run_slot(input int dmode);
    bit dreq, d_we, was_xfer;
    logic [AW-1:0] d_a;
    logic [DW-1:0] d_d;
    int nm;
    if (m == P_IDLE) begin
      cpu_req = nx_valid;
      if (nx_valid) begin
        cpu_we = nx_we; cpu_addr = nx_a; cpu_wdata = nx_d;
      end
    end else begin
      // R7: scramble CPU inputs during an access
      cpu_addr  = AW'($urandom);
      cpu_wdata = DW'($urandom);
      cpu_we    = 1'($urandom);
    end
    dreq = (dmode == 1) ? 1'b1 : (dmode == 2) ? 1'($urandom) : 1'b0;
    d_we = 1'($urandom);
    d_a  = AW'(HALF + ($urandom % HALF));
    d_d  = DW'($urandom);
    dma_req = dreq; dma_we = d_we; dma_addr = d_a; dma_wdata = d_d;
    nm = model_next(m, cpu_req, dreq);
    if (m == P_IDLE && cpu_req) begin
      cap_we_m = cpu_we; cap_a_m = cpu_addr; cap_d_m = cpu_wdata;
      waits_m = 0; acc_cyc = cyc;
      if (slot_no % 2 == 0) starts_even++; else starts_odd++;
    end
    was_xfer = (m == P_XFER);
    m = nm;
    if (m == P_WAIT) waits_m++;
    @(negedge clk);
    slot_no++;
    check(dma_gnt == dreq, "R4 grant", dma_gnt, dreq);
    check(cpu_wait == (m == P_WAIT), "R5 wait", cpu_wait, (m == P_WAIT));
    check(cpu_ready == was_xfer, "R6 ready", cpu_ready, was_xfer);
    check(slot_strobe == 1'b0, "R1 strobe off", slot_strobe, 0);
    if (was_xfer) begin
      check(cyc - acc_cyc == exp_latency(waits_m),
            (waits_m == 0) ? "R2 latency" : "R5 latency", cyc - acc_cyc, exp_latency(waits_m));
      if (cap_we_m) begin
        ref_mem[cap_a_m] = cap_d_m;
      end else begin
        check(cpu_rdata == ref_mem[cap_a_m], "R10 cpu read", cpu_rdata, ref_mem[cap_a_m]);
        last_rdata = ref_mem[cap_a_m];
      end
      cpu_req = 0;
      nx_valid = 0;
    end else begin
      check(cpu_rdata == last_rdata, "R8 rdata held", cpu_rdata, last_rdata);
    end
    if (dreq) begin
      check(mem_en && mem_addr == d_a && mem_we == d_we,
            (m == P_ADDR) ? "R3 dma in addr slot" : "R4 dma port", mem_addr, d_a);
      if (d_we) begin
        check(mem_wdata == d_d, "R4 dma wdata", mem_wdata, d_d);
        ref_mem[d_a] = d_d;
      end else begin
        check(dma_rdata == ref_mem[d_a], "R10 dma read", dma_rdata, ref_mem[d_a]);
      end
    end else if (m == P_XFER) begin
      check(mem_en && mem_addr == cap_a_m && mem_we == cap_we_m, "R7 held addr", mem_addr, cap_a_m);
      if (cap_we_m) check(mem_wdata == cap_d_m, "R7 held wdata", mem_wdata, cap_d_m);
    end else begin
      check(mem_en == 1'b0, (m == P_ADDR) ? "R3 addr slot idle" : "R4 idle slot", mem_en, 0);
    end
    for (int k = 1; k < SC; k++) begin
      @(negedge clk);
      check(cpu_ready == 1'b0, "R6 single pulse", cpu_ready, 0);
      check(slot_strobe == (k == SC - 1), "R1 strobe", slot_strobe, (k == SC - 1));
    end
  endtask

  task automatic do_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d, input int dmode);
    nx_valid = 1; nx_we = we; nx_a = a; nx_d = d;
    for (int g = 0; g < 400 && nx_valid; g++) run_slot(dmode);
    check(nx_valid == 0, "R5 access completes", nx_valid, 0);
  endtask

  initial begin
    int n;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    check(cpu_ready == 0 && dma_gnt == 0 && mem_en == 0 && cpu_wait == 0,
          "R6 reset outputs", {cpu_ready, dma_gnt, mem_en, cpu_wait}, 0);
    rst_n = 1'b1;
    n = 0;
    @(negedge clk); n++;
    while (!slot_strobe && n < 20) begin @(negedge clk); n++; end
    check(n == SC - 1, "R1 first strobe", n, SC - 1);

    // no DMA load: writes then reads, gaps shift parity (R9)
    for (int i = 0; i < 6; i++) begin
      for (int g = 0; g < i % 2; g++) run_slot(0);
      do_op(1'b1, AW'(i * 7 + 3), DW'(16'h1000 + i * 16'h0111), 0);
    end
    for (int i = 0; i < 6; i++) begin
      for (int g = 0; g < (i + 1) % 2; g++) run_slot(0);
      do_op(1'b0, AW'(i * 7 + 3), '0, 0);
    end

    // DMA on every slot: CPU stalls (R5), address slot shared (R3)
    nx_valid = 1; nx_we = 1'b0; nx_a = AW'(10); nx_d = '0;
    for (int s = 0; s < 20; s++) run_slot(1);
    check(nx_valid == 1 && cpu_wait == 1, "R5 stall under full DMA", nx_valid, 1);
    for (int g = 0; g < 10 && nx_valid; g++) run_slot(0);
    check(nx_valid == 0, "R5 release after DMA", nx_valid, 0);

    // random DMA demand and random CPU traffic
    for (int i = 0; i < 120; i++) begin
      for (int g = 0; g < int'($urandom % 3); g++) run_slot(2);
      do_op(1'($urandom), AW'($urandom % HALF), DW'($urandom), 2);
    end

    check(starts_even > 0 && starts_odd > 0, "R9 both parities", starts_odd, starts_even);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule